// File: doc/BRIEF.md
# Hsync-Referenced Clamp and Sync Shaper

This block sits on the pixel clock of a three-channel video digitizer. It produces the strobe that tells the analog front end when to pull each channel to its black reference, and it regenerates a clean horizontal sync pulse for the display pipeline downstream. The raw horizontal sync input and the external clamp pin are both asynchronous. Each passes through a two-flop synchronizer before any edge is detected.

In internal mode, the clamp window opens a programmed number of pixel periods after the trailing edge of the incoming sync pulse. It stays open for a second programmed number of pixel periods. In external mode, the clamp follows the external pin, and a configuration bit chooses which pin level means "clamp". The leading edge of the incoming sync starts an outgoing sync pulse. Its width in pixel clocks is programmed, and its polarity is selectable. The control values are quasi-static: firmware sets them while the video is idle.

Top module: `hsync_clamp_gen`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `clamp_out` is 0 and `hsync_out` sits at its inactive level, which is the inverse of `cfg_hs_out_high`.
- R2: With `cfg_clamp_ext`=0, `clamp_out` rises on the rising clock edge numbered S+3, where S is `cfg_clamp_start`. Edge 0 is the first rising edge after `hsync_in` changes from its active to its inactive level, the trailing edge.
- R3: In internal mode, `clamp_out` stays high for exactly `cfg_clamp_len` clock cycles (1 to 255).
- R4: In internal mode, a `cfg_clamp_len` of 0 produces no clamp pulse at all.
- R5: A `cfg_clamp_start` of 0 is treated as 1.
- R6: With `cfg_clamp_ext`=1, the clamp timing values are ignored and `clamp_out` follows the external pin, delayed by 2 clock edges. When `cfg_clamp_pin_low`=0, the clamp is active while `clamp_pin` is 1. When `cfg_clamp_pin_low`=1, it is active while `clamp_pin` is 0.
- R7: `cfg_hs_in_high`=1 makes a rising `hsync_in` the leading edge and a falling one the trailing edge. `cfg_hs_in_high`=0 swaps the two. With the wrong setting, the clamp is timed from the opposite input edge.
- R8: `hsync_out` becomes active on edge 3 after a leading input edge, counting the first rising edge after the change as edge 0. It stays active for `cfg_hs_width` clock cycles (1 to 255).
- R9: `cfg_hs_out_high`=1 makes the active level of `hsync_out` high. A value of 0 makes it low.
- R10: A `cfg_hs_width` of 0 produces no output sync pulse.
- R11: A trailing input edge that arrives while a clamp window is pending or open closes the window. Placement then restarts from the new trailing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Raw horizontal sync, asynchronous |
| clamp_pin | input | 1 | External clamp request, asynchronous |
| cfg_clamp_start | input | CNT_W | Pixel periods from the trailing sync edge to the clamp start |
| cfg_clamp_len | input | CNT_W | Clamp window length in pixel periods |
| cfg_clamp_ext | input | 1 | 1 selects the external clamp pin, 0 selects the internal timer |
| cfg_clamp_pin_low | input | 1 | 1 means the external pin clamps when low |
| cfg_hs_in_high | input | 1 | 1 means the input sync pulse is active high |
| cfg_hs_out_high | input | 1 | 1 means the output sync pulse is active high |
| cfg_hs_width | input | CNT_W | Output sync pulse width in pixel clocks |
| clamp_out | output | 1 | Registered clamp strobe, active high |
| hsync_out | output | 1 | Registered, shaped horizontal sync |

## Verification
The properties assume the configuration inputs change only rarely. They hold only after the mode and length settings have been steady for longer than the largest possible window. The external-pin property counts cycles from reset before it arms, so that the synchronizer can fill first. The stimulus follows these assumptions: every configuration change is followed by a quiet interval of several hundred cycles, with the sync input held at its idle level, before a line is driven. All pins are driven on the falling clock edge.

// File: rtl/hcg_pkg.sv
package hcg_pkg;
  typedef enum logic [1:0] {
    CT_IDLE,
    CT_WAIT,
    CT_OPEN
  } clamp_state_e;
endpackage

// File: rtl/hcg_sync.sv
module hcg_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hcg_edge.sv
module hcg_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_s,
  input  logic act_high,
  output logic primed,
  output logic lead,
  output logic trail
);
  localparam int PW = $clog2(STAGES + 2);
  localparam logic [PW-1:0] PRIME_AT = PW'(STAGES + 1);

  logic [PW-1:0] pcnt;
  logic act, act_d;

  // normalise so that 1 always means "sync pulse active"
  assign act    = act_high ? raw_s : ~raw_s;
  assign primed = (pcnt == PRIME_AT);

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt  <= '0;
      act_d <= 1'b0;
    end else begin
      act_d <= act;
      if (!primed) pcnt <= pcnt + 1'b1;
    end
  end

  // edges are masked until the synchronizer and history flop hold real data
  assign lead  = primed &  act & ~act_d;
  assign trail = primed & ~act &  act_d;
endmodule

// File: rtl/hcg_clamp_timer.sv
module hcg_clamp_timer
  import hcg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         trail,
  input  logic [W-1:0] start,
  input  logic [W-1:0] len,
  output logic         win
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  clamp_state_e st;
  logic [W-1:0] pos;
  logic [W-1:0] rem;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= CT_IDLE;
      pos <= '0;
      rem <= '0;
      win <= 1'b0;
    end else if (trail) begin
      // every trailing edge (re)arms placement and drops any open window
      st  <= CT_WAIT;
      pos <= start;
      win <= 1'b0;
    end else begin
      case (st)
        CT_WAIT: begin
          if (pos <= ONE) begin
            if (len != '0) begin
              st  <= CT_OPEN;
              rem <= len;
              win <= 1'b1;
            end else begin
              st <= CT_IDLE;
            end
          end else begin
            pos <= pos - ONE;
          end
        end
        CT_OPEN: begin
          if (rem <= ONE) begin
            win <= 1'b0;
            st  <= CT_IDLE;
          end else begin
            rem <= rem - ONE;
          end
        end
        default: st <= CT_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hcg_hs_shaper.sv
module hcg_hs_shaper #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         lead,
  input  logic [W-1:0] width,
  input  logic         out_high,
  output logic         hs_out
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic         busy;
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (lead) begin
      busy <= (width != '0);
      cnt  <= width;
    end else if (busy) begin
      if (cnt <= ONE) busy <= 1'b0;
      else            cnt  <= cnt - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) hs_out <= ~out_high;
    else     hs_out <= out_high ? busy : ~busy;
  end
endmodule

// File: rtl/hsync_clamp_gen.sv
module hsync_clamp_gen #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hsync_in,
  input  logic             clamp_pin,
  input  logic [CNT_W-1:0] cfg_clamp_start,
  input  logic [CNT_W-1:0] cfg_clamp_len,
  input  logic             cfg_clamp_ext,
  input  logic             cfg_clamp_pin_low,
  input  logic             cfg_hs_in_high,
  input  logic             cfg_hs_out_high,
  input  logic [CNT_W-1:0] cfg_hs_width,
  output logic             clamp_out,
  output logic             hsync_out
);
  localparam int NPIN = 2;

  logic [NPIN-1:0] pins_s;
  logic primed, lead, trail, win;
  logic pin_act;

  hcg_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({clamp_pin, hsync_in}),
    .q   (pins_s)
  );

  hcg_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .raw_s    (pins_s[0]),
    .act_high (cfg_hs_in_high),
    .primed   (primed),
    .lead     (lead),
    .trail    (trail)
  );

  hcg_clamp_timer #(.W(CNT_W)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .trail (trail),
    .start (cfg_clamp_start),
    .len   (cfg_clamp_len),
    .win   (win)
  );

  hcg_hs_shaper #(.W(CNT_W)) u_shaper (
    .clk      (clk),
    .rst      (rst),
    .lead     (lead),
    .width    (cfg_hs_width),
    .out_high (cfg_hs_out_high),
    .hs_out   (hsync_out)
  );

  assign pin_act = pins_s[1] ^ cfg_clamp_pin_low;

  always_ff @(posedge clk) begin
    if (rst)                clamp_out <= 1'b0;
    else if (cfg_clamp_ext) clamp_out <= primed & pin_act;
    else                    clamp_out <= win;
  end
endmodule

// File: rtl/hcg_chk.sv
module hcg_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             clamp_pin,
  input logic             cfg_clamp_ext,
  input logic             cfg_clamp_pin_low,
  input logic [CNT_W-1:0] cfg_clamp_len,
  input logic [CNT_W-1:0] cfg_hs_width,
  input logic             cfg_hs_out_high,
  input logic             clamp_out,
  input logic             hsync_out
);
  localparam int CW   = CNT_W + 3;
  localparam int LONG = (1 << CNT_W) + 4;
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [CW-1:0] LONG_C = CW'(2 * LONG);
  localparam logic [CW-1:0] WLONG_C = CW'(LONG);

  logic [3:0]       warm;
  logic [CW-1:0]    calm;
  logic [CW-1:0]    w0;
  logic [CW-1:0]    run;
  logic [CNT_W-1:0] len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      warm  <= '0;
      calm  <= '0;
      w0    <= '0;
      run   <= '0;
      len_q <= cfg_clamp_len;
    end else begin
      len_q <= cfg_clamp_len;
      if (warm != 4'hF) warm <= warm + 1'b1;
      if (cfg_clamp_ext || cfg_clamp_len != len_q) calm <= '0;
      else if (calm != CMAX)                       calm <= calm + 1'b1;
      if (cfg_hs_width != '0) w0 <= '0;
      else if (w0 != CMAX)    w0 <= w0 + 1'b1;
      if (!clamp_out)         run <= '0;
      else if (run != CMAX)   run <= run + 1'b1;
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> (!clamp_out && (hsync_out == !$past(cfg_hs_out_high))));

  // R6
  ext_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (warm > 4'd6 && $past(cfg_clamp_ext))
      |-> (clamp_out == ($past(clamp_pin, 3) ^ $past(cfg_clamp_pin_low))));

  // R4
  no_len0_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (warm > 4'd6 && !$past(cfg_clamp_ext) && !$past(cfg_clamp_ext, 2)
     && $past(cfg_clamp_len) == '0 && $past(cfg_clamp_len, 2) == '0)
      |-> !$rose(clamp_out));

  // R3
  clamp_len_chk: assert property (@(posedge clk) disable iff (rst)
    (calm > LONG_C) |-> (run <= CW'(cfg_clamp_len)));

  // R10
  no_width0_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (w0 > WLONG_C) |-> (hsync_out != $past(cfg_hs_out_high)));
endmodule

bind hsync_clamp_gen hcg_chk #(.CNT_W(CNT_W)) u_chk (
  .clk               (clk),
  .rst               (rst),
  .clamp_pin         (clamp_pin),
  .cfg_clamp_ext     (cfg_clamp_ext),
  .cfg_clamp_pin_low (cfg_clamp_pin_low),
  .cfg_clamp_len     (cfg_clamp_len),
  .cfg_hs_width      (cfg_hs_width),
  .cfg_hs_out_high   (cfg_hs_out_high),
  .clamp_out         (clamp_out),
  .hsync_out         (hsync_out)
);

// File: tb/sim_hsync_clamp_gen.sv
module sim_hsync_clamp_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hsync_in = 1'b0;
  logic clamp_pin = 1'b0;
  logic [7:0] cfg_clamp_start = 8'd9;
  logic [7:0] cfg_clamp_len = 8'd20;
  logic cfg_clamp_ext = 1'b0;
  logic cfg_clamp_pin_low = 1'b0;
  logic cfg_hs_in_high = 1'b1;
  logic cfg_hs_out_high = 1'b1;
  logic [7:0] cfg_hs_width = 8'd5;
  logic clamp_out, hsync_out;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  logic act_lvl = 1'b1;
  logic cl_s [0:299];
  logic hs_s [0:299];

  always #5 clk = ~clk;

  hsync_clamp_gen u0 (
    .clk(clk), .rst(rst), .hsync_in(hsync_in), .clamp_pin(clamp_pin),
    .cfg_clamp_start(cfg_clamp_start), .cfg_clamp_len(cfg_clamp_len),
    .cfg_clamp_ext(cfg_clamp_ext), .cfg_clamp_pin_low(cfg_clamp_pin_low),
    .cfg_hs_in_high(cfg_hs_in_high), .cfg_hs_out_high(cfg_hs_out_high),
    .cfg_hs_width(cfg_hs_width), .clamp_out(clamp_out), .hsync_out(hsync_out)
  );

  task automatic check(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    hsync_in = ~act_lvl;
    repeat (600) @(posedge clk);
    @(negedge clk);
  endtask

  // hsync_in goes active before edge 0; toggles after sample j == t1, t2, t3
  task automatic run_line(int t1, int t2, int t3, int n);
    hsync_in = act_lvl;
    for (int j = 0; j < n; j++) begin
      @(posedge clk);
      @(negedge clk);
      cl_s[j] = clamp_out;
      hs_s[j] = (hsync_out == cfg_hs_out_high);
      if (j == t1 || j == t3) hsync_in = ~act_lvl;
      if (j == t2) hsync_in = act_lvl;
    end
  endtask

  function automatic int first_of(bit hs, int n);
    for (int j = 0; j < n; j++) if ((hs ? hs_s[j] : cl_s[j]) === 1'b1) return j;
    return -1;
  endfunction

  function automatic int last_of(bit hs, int n);
    int r = -1;
    for (int j = 0; j < n; j++) if ((hs ? hs_s[j] : cl_s[j]) === 1'b1) r = j;
    return r;
  endfunction

  function automatic int count_of(bit hs, int n);
    int c = 0;
    for (int j = 0; j < n; j++) if ((hs ? hs_s[j] : cl_s[j]) === 1'b1) c++;
    return c;
  endfunction

  task automatic defaults();
    cfg_clamp_start = 8'd9; cfg_clamp_len = 8'd20; cfg_clamp_ext = 1'b0;
    cfg_clamp_pin_low = 1'b0; cfg_hs_in_high = 1'b1; cfg_hs_out_high = 1'b1;
    cfg_hs_width = 8'd5; act_lvl = 1'b1; clamp_pin = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 clamp during reset", clamp_out, 0);
    check("R1 hsync idle during reset", hsync_out, 0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R1 clamp after reset", clamp_out, 0);
  endtask

  task automatic t_basic();
    defaults(); settle();
    run_line(5, -9, -9, 60);       // trailing edge at edge 6
    check("R2 clamp start 9", first_of(0, 60), 6 + 9 + 3);
    check("R3 clamp length 20", count_of(0, 60), 20);
    check("R8 hsync start", first_of(1, 60), 3);
    check("R8 hsync width 5", count_of(1, 60), 5);
  endtask

  task automatic t_min();
    defaults(); cfg_clamp_start = 8'd1; cfg_clamp_len = 8'd1; settle();
    run_line(2, -9, -9, 40);
    check("R2 clamp start 1", first_of(0, 40), 3 + 1 + 3);
    check("R3 clamp length 1", count_of(0, 40), 1);
  endtask

  task automatic t_start0();
    defaults(); cfg_clamp_start = 8'd0; cfg_clamp_len = 8'd3; settle();
    run_line(2, -9, -9, 40);
    check("R5 start 0 acts as 1", first_of(0, 40), 3 + 1 + 3);
    check("R5 length with start 0", count_of(0, 40), 3);
  endtask

  task automatic t_len0();
    defaults(); cfg_clamp_len = 8'd0; settle();
    run_line(5, -9, -9, 60);
    check("R4 no clamp when length 0", count_of(0, 60), 0);
  endtask

  task automatic t_retrig();
    defaults(); cfg_clamp_start = 8'd4; cfg_clamp_len = 8'd10; settle();
    run_line(1, 12, 14, 50);
    check("R11 first window start", first_of(0, 50), 9);
    check("R11 open before restart", cl_s[17], 1);
    check("R11 closed by new trail", cl_s[18], 0);
    check("R11 restarted window end", last_of(0, 50), 31);
    check("R11 total clamp cycles", count_of(0, 50), 19);
  endtask

  task automatic t_ext();
    defaults(); cfg_clamp_ext = 1'b1; settle();
    run_line(5, -9, -9, 60);
    check("R6 timer ignored in external mode", count_of(0, 60), 0);
    clamp_pin = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R6 pin high edge0", clamp_out, 0);
    @(posedge clk); @(negedge clk);
    check("R6 pin high edge1", clamp_out, 0);
    @(posedge clk); @(negedge clk);
    check("R6 pin high edge2", clamp_out, 1);
    cfg_clamp_pin_low = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R6 active-low pin held high", clamp_out, 0);
    clamp_pin = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R6 active-low pin driven low", clamp_out, 1);
    clamp_pin = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R6 active-low pin released", clamp_out, 0);
  endtask

  task automatic t_in_low();
    defaults(); cfg_hs_in_high = 1'b0; act_lvl = 1'b0; settle();
    run_line(5, -9, -9, 60);
    check("R7 active-low input clamp start", first_of(0, 60), 18);
    check("R7 active-low input hsync start", first_of(1, 60), 3);
  endtask

  task automatic t_in_wrong();
    defaults(); act_lvl = 1'b0; settle();  // config says active high, line is active low
    run_line(5, -9, -9, 60);
    check("R7 wrong polarity clamp from opposite edge", first_of(0, 60), 0 + 9 + 3);
    check("R7 wrong polarity hsync from opposite edge", first_of(1, 60), 6 + 3);
  endtask

  task automatic t_out_low();
    defaults(); cfg_hs_out_high = 1'b0; settle();
    check("R9 idle level high when active low", hsync_out, 1);
    run_line(5, -9, -9, 60);
    check("R9 low pulse start", first_of(1, 60), 3);
    check("R9 low pulse width", count_of(1, 60), 5);
  endtask

  task automatic t_width();
    defaults(); cfg_hs_width = 8'd0; settle();
    run_line(5, -9, -9, 60);
    check("R10 no pulse when width 0", count_of(1, 60), 0);
    defaults(); cfg_hs_width = 8'd200; settle();
    run_line(5, -9, -9, 260);
    check("R8 width 200 start", first_of(1, 260), 3);
    check("R8 width 200 length", count_of(1, 260), 200);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_min();
    t_start0();
    t_len0();
    t_retrig();
    t_ext();
    t_in_low();
    t_in_wrong();
    t_out_low();
    t_width();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule